// File: doc/BRIEF.md
# Isochronous Frame-Completion Interrupt Tracker

This block watches the isochronous endpoints of a device controller over each bus frame and reports, at the end of the periodic frame, whether any enabled isochronous IN endpoint or any enabled isochronous OUT endpoint failed to finish its transfer. Each endpoint's completion is tracked from the start-of-frame pulse onward. At the end-of-periodic-frame pulse the block raises a frame-end flag. In the same cycle it raises one incomplete flag per direction if that direction has an unfinished enabled isochronous endpoint.

Every endpoint also has a small vector of interrupt sources. Bit 0 of that vector is always the transfer-complete event. All status flags are sticky and software clears them by writing 1. Two mask registers each hold one enable bit per source. One applies to every IN endpoint and the other to every OUT endpoint, so a single bit silences a given source on all endpoints of that direction, endpoint 0 included. A single registered interrupt line combines the unmasked endpoint flags with the global flags.

Top module: `iso_incomplete_irq`

## Requirements
- R1: After reset all endpoint status bits, all global flags and the interrupt line are 0. Both mask registers are also 0, so every per-endpoint source is masked.
- R2: An endpoint status bit at position ep*SRC_W+s is set by the event on the same bit. It stays set until it is cleared. An event in the same cycle as a clear of that bit leaves the bit set.
- R3: A clear write of 1 on a bit clears only that bit. Bits written 0 keep their value.
- R4: The global flag vector has bit 0 = frame end, bit 1 = IN isochronous incomplete and bit 2 = OUT isochronous incomplete. Bit 0 is set on the edge where the end-of-periodic-frame pulse is sampled.
- R5: Bit 1 is set at end of frame when at least one IN endpoint is both enabled and isochronous and has had no transfer-complete event since the last start-of-frame pulse. A completion in the end-of-frame cycle itself counts as done.
- R6: Bit 2 follows the same rule for OUT endpoints, independently of the IN side.
- R7: The incomplete flags change only on an end-of-frame cycle. An endpoint that is not enabled, or that is not isochronous, never causes them.
- R8: The start-of-frame pulse forgets all completions from the previous frame. A completion in the same cycle as start-of-frame counts for the new frame.
- R9: IN mask bit s enables source s on every IN endpoint, endpoint 0 included, for the interrupt line only. The status bits still record events while masked.
- R10: The OUT mask works the same way on OUT endpoints and is independent of the IN mask.
- R11: The interrupt line is registered. It is the OR of the unmasked endpoint status bits and all global flags, and it updates on the same edge as the status bits. A mask write takes effect on the line from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame pulse |
| eopf_i | input | 1 | End-of-periodic-frame pulse |
| in_en_i | input | N_IN | IN endpoint enabled in this frame |
| in_iso_i | input | N_IN | IN endpoint is isochronous |
| in_evt_i | input | N_IN*SRC_W | IN per-endpoint source events; bit 0 of each group is transfer complete |
| in_clr_i | input | N_IN*SRC_W | IN status write-1-to-clear |
| out_en_i | input | N_OUT | OUT endpoint enabled in this frame |
| out_iso_i | input | N_OUT | OUT endpoint is isochronous |
| out_evt_i | input | N_OUT*SRC_W | OUT per-endpoint source events; bit 0 of each group is transfer complete |
| out_clr_i | input | N_OUT*SRC_W | OUT status write-1-to-clear |
| glb_clr_i | input | 3 | Global flag write-1-to-clear |
| in_msk_we_i | input | 1 | IN mask write strobe |
| in_msk_i | input | SRC_W | IN mask write data |
| out_msk_we_i | input | 1 | OUT mask write strobe |
| out_msk_i | input | SRC_W | OUT mask write data |
| in_sts_o | output | N_IN*SRC_W | IN endpoint status |
| out_sts_o | output | N_OUT*SRC_W | OUT endpoint status |
| glb_sts_o | output | 3 | Global flags |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The assertions assume single-cycle frame pulses and stable endpoint enable and type bits within a frame. They assume no start-of-frame and end-of-frame pulse in the same cycle, and no mask write data that changes while its strobe is low. The stimulus holds enable and type at fixed values, pulses start-of-frame and end-of-frame in separate cycles, and changes masks only through single strobed writes. Events and clears are then combined freely within those limits, including same-cycle set and clear.

// File: rtl/iso_irq_pkg.sv
package iso_irq_pkg;
  localparam int GLB_W = 3;
  typedef enum int {
    GLB_FRAME_END = 0,
    GLB_ISO_IN    = 1,
    GLB_ISO_OUT   = 2
  } glb_bit_e;
endpackage

// File: rtl/iso_frame_track.sv
module iso_frame_track #(
  parameter int N_EP = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sof_i,
  input  logic            eopf_i,
  input  logic [N_EP-1:0] en_i,
  input  logic [N_EP-1:0] iso_i,
  input  logic [N_EP-1:0] cmp_i,
  output logic            incomplete_o
);
  logic [N_EP-1:0] done_q;
  logic [N_EP-1:0] done_now;
  logic [N_EP-1:0] pending;

  assign done_now = done_q | cmp_i;
  assign pending  = en_i & iso_i & ~done_now;
  assign incomplete_o = eopf_i && (|pending);

  always_ff @(posedge clk) begin
    if (rst)        done_q <= '0;
    else if (sof_i) done_q <= cmp_i;
    else            done_q <= done_now;
  end

  // R8
  new_frame_forgets_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sof_i) && $past(cmp_i) == '0 && eopf_i && cmp_i == '0 &&
     (en_i & iso_i) != '0) |-> incomplete_o);
endmodule

// File: rtl/w1c_status.sv
module w1c_status #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_q,
  output logic [W-1:0] sts_nx
);
  assign sts_nx = (sts_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= sts_nx;
  end

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0));
  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/src_mask.sv
module src_mask #(
  parameter int SRC_W = 2,
  parameter int N_EP  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we_i,
  input  logic [SRC_W-1:0]       wdata_i,
  input  logic [N_EP*SRC_W-1:0]  sts_i,
  output logic                   hit_o
);
  localparam int W = N_EP * SRC_W;
  logic [SRC_W-1:0] msk_q;
  logic [W-1:0]     msk_wide;

  for (genvar e = 0; e < N_EP; e++) begin : g_rep
    assign msk_wide[e*SRC_W +: SRC_W] = msk_q;
  end

  assign hit_o = |(sts_i & msk_wide);

  always_ff @(posedge clk) begin
    if (rst)       msk_q <= '0;
    else if (we_i) msk_q <= wdata_i;
  end

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(msk_q));
endmodule

// File: rtl/iso_incomplete_irq.sv
module iso_incomplete_irq
  import iso_irq_pkg::*;
#(
  parameter int N_IN  = 5,
  parameter int N_OUT = 5,
  parameter int SRC_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sof_i,
  input  logic                   eopf_i,
  input  logic [N_IN-1:0]        in_en_i,
  input  logic [N_IN-1:0]        in_iso_i,
  input  logic [N_IN*SRC_W-1:0]  in_evt_i,
  input  logic [N_IN*SRC_W-1:0]  in_clr_i,
  input  logic [N_OUT-1:0]       out_en_i,
  input  logic [N_OUT-1:0]       out_iso_i,
  input  logic [N_OUT*SRC_W-1:0] out_evt_i,
  input  logic [N_OUT*SRC_W-1:0] out_clr_i,
  input  logic [GLB_W-1:0]       glb_clr_i,
  input  logic                   in_msk_we_i,
  input  logic [SRC_W-1:0]       in_msk_i,
  input  logic                   out_msk_we_i,
  input  logic [SRC_W-1:0]       out_msk_i,
  output logic [N_IN*SRC_W-1:0]  in_sts_o,
  output logic [N_OUT*SRC_W-1:0] out_sts_o,
  output logic [GLB_W-1:0]       glb_sts_o,
  output logic                   irq_o
);
  localparam int IN_W  = N_IN * SRC_W;
  localparam int OUT_W = N_OUT * SRC_W;

  logic [N_IN-1:0]  in_cmp;
  logic [N_OUT-1:0] out_cmp;
  logic             in_inc, out_inc;
  logic [IN_W-1:0]  in_nx;
  logic [OUT_W-1:0] out_nx;
  logic [GLB_W-1:0] glb_set, glb_nx;
  logic             in_hit, out_hit;
  logic             irq_q;

  for (genvar e = 0; e < N_IN; e++) begin : g_in_cmp
    assign in_cmp[e] = in_evt_i[e*SRC_W];
  end
  for (genvar e = 0; e < N_OUT; e++) begin : g_out_cmp
    assign out_cmp[e] = out_evt_i[e*SRC_W];
  end

  iso_frame_track #(.N_EP(N_IN)) u_in_trk (
    .clk(clk), .rst(rst), .sof_i(sof_i), .eopf_i(eopf_i),
    .en_i(in_en_i), .iso_i(in_iso_i), .cmp_i(in_cmp), .incomplete_o(in_inc));

  iso_frame_track #(.N_EP(N_OUT)) u_out_trk (
    .clk(clk), .rst(rst), .sof_i(sof_i), .eopf_i(eopf_i),
    .en_i(out_en_i), .iso_i(out_iso_i), .cmp_i(out_cmp), .incomplete_o(out_inc));

  w1c_status #(.W(IN_W)) u_in_sts (
    .clk(clk), .rst(rst), .set_i(in_evt_i), .clr_i(in_clr_i),
    .sts_q(in_sts_o), .sts_nx(in_nx));

  w1c_status #(.W(OUT_W)) u_out_sts (
    .clk(clk), .rst(rst), .set_i(out_evt_i), .clr_i(out_clr_i),
    .sts_q(out_sts_o), .sts_nx(out_nx));

  always_comb begin
    glb_set = '0;
    glb_set[GLB_FRAME_END] = eopf_i;
    glb_set[GLB_ISO_IN]    = in_inc;
    glb_set[GLB_ISO_OUT]   = out_inc;
  end

  w1c_status #(.W(GLB_W)) u_glb_sts (
    .clk(clk), .rst(rst), .set_i(glb_set), .clr_i(glb_clr_i),
    .sts_q(glb_sts_o), .sts_nx(glb_nx));

  src_mask #(.SRC_W(SRC_W), .N_EP(N_IN)) u_in_msk (
    .clk(clk), .rst(rst), .we_i(in_msk_we_i), .wdata_i(in_msk_i),
    .sts_i(in_nx), .hit_o(in_hit));

  src_mask #(.SRC_W(SRC_W), .N_EP(N_OUT)) u_out_msk (
    .clk(clk), .rst(rst), .we_i(out_msk_we_i), .wdata_i(out_msk_i),
    .sts_i(out_nx), .hit_o(out_hit));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= in_hit | out_hit | (|glb_nx);
  end
  assign irq_o = irq_q;

  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (in_sts_o == '0 && out_sts_o == '0 && glb_sts_o == '0) |-> !irq_o);
  // R4
  frame_end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    eopf_i |=> glb_sts_o[GLB_FRAME_END]);
  // R5
  in_inc_only_at_eopf_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(glb_sts_o[GLB_ISO_IN]) |-> $past(eopf_i));
  // R6
  out_inc_only_at_eopf_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(glb_sts_o[GLB_ISO_OUT]) |-> $past(eopf_i));
endmodule

// File: tb/iso_incomplete_irq_test.sv
`timescale 1ns/100ps
module iso_incomplete_irq_test;
  typedef struct packed {
    logic [3:0] req;
    logic       sof;
    logic       eopf;
    logic [9:0] in_evt;
    logic [9:0] in_clr;
    logic [9:0] out_evt;
    logic [9:0] out_clr;
    logic [2:0] glb_clr;
    logic [9:0] exp_in;
    logic [9:0] exp_out;
    logic [2:0] exp_glb;
    logic       exp_irq;
  } vec_t;

  // IN: ep0,ep1 iso+enabled, ep2 enabled bulk, ep3 iso not enabled.
  // OUT: ep4 iso+enabled, ep0 enabled non-iso. Masks 2'b11 during table.
  localparam vec_t TBL [13] = '{
    '{4'd8,  1'b1,1'b0,10'h000,10'h000,10'h000,10'h000,3'b000,10'h000,10'h000,3'b000,1'b0}, // R8 sof
    '{4'd7,  1'b0,1'b0,10'h001,10'h000,10'h000,10'h000,3'b000,10'h001,10'h000,3'b000,1'b1}, // R7 no flag mid-frame
    '{4'd3,  1'b0,1'b0,10'h000,10'h001,10'h000,10'h000,3'b000,10'h000,10'h000,3'b000,1'b0}, // R3 clear
    '{4'd5,  1'b0,1'b1,10'h000,10'h000,10'h000,10'h000,3'b000,10'h000,10'h000,3'b111,1'b1}, // R5 R6 ep1/ep4 pending
    '{4'd4,  1'b0,1'b0,10'h000,10'h000,10'h000,10'h000,3'b111,10'h000,10'h000,3'b000,1'b0}, // R4 clear globals
    '{4'd8,  1'b1,1'b0,10'h004,10'h000,10'h100,10'h000,3'b000,10'h004,10'h100,3'b000,1'b1}, // R8 cmp with sof
    '{4'd3,  1'b0,1'b0,10'h001,10'h004,10'h000,10'h100,3'b000,10'h001,10'h000,3'b000,1'b1}, // R3 selective clear
    '{4'd7,  1'b0,1'b1,10'h000,10'h001,10'h000,10'h000,3'b000,10'h000,10'h000,3'b001,1'b1}, // R7 all iso done
    '{4'd2,  1'b0,1'b0,10'h020,10'h020,10'h000,10'h000,3'b001,10'h020,10'h000,3'b000,1'b1}, // R2 set beats clear
    '{4'd11, 1'b0,1'b0,10'h000,10'h020,10'h000,10'h000,3'b000,10'h000,10'h000,3'b000,1'b0}, // R11 idle
    '{4'd8,  1'b1,1'b0,10'h000,10'h000,10'h000,10'h000,3'b000,10'h000,10'h000,3'b000,1'b0}, // R8 new frame
    '{4'd6,  1'b0,1'b1,10'h005,10'h000,10'h000,10'h000,3'b000,10'h005,10'h000,3'b101,1'b1}, // R5 R6 cmp at eopf
    '{4'd3,  1'b0,1'b0,10'h000,10'h005,10'h000,10'h000,3'b111,10'h000,10'h000,3'b000,1'b0}  // R3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof = 1'b0, eopf = 1'b0;
  logic [4:0] in_en = 5'b00111, in_iso = 5'b01011;
  logic [4:0] out_en = 5'b10001, out_iso = 5'b10000;
  logic [9:0] in_evt = '0, in_clr = '0, out_evt = '0, out_clr = '0;
  logic [2:0] glb_clr = '0;
  logic in_we = 1'b0, out_we = 1'b0;
  logic [1:0] in_m = '0, out_m = '0;
  logic [9:0] in_sts, out_sts;
  logic [2:0] glb_sts;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iso_incomplete_irq uut (
    .clk(clk), .rst(rst), .sof_i(sof), .eopf_i(eopf),
    .in_en_i(in_en), .in_iso_i(in_iso), .in_evt_i(in_evt), .in_clr_i(in_clr),
    .out_en_i(out_en), .out_iso_i(out_iso), .out_evt_i(out_evt), .out_clr_i(out_clr),
    .glb_clr_i(glb_clr), .in_msk_we_i(in_we), .in_msk_i(in_m),
    .out_msk_we_i(out_we), .out_msk_i(out_m),
    .in_sts_o(in_sts), .out_sts_o(out_sts), .glb_sts_o(glb_sts), .irq_o(irq));

  task automatic run(input vec_t v);
    logic [23:0] act, exp;
    @(negedge clk);
    sof = v.sof; eopf = v.eopf; in_evt = v.in_evt; in_clr = v.in_clr;
    out_evt = v.out_evt; out_clr = v.out_clr; glb_clr = v.glb_clr;
    @(posedge clk); #1;
    sof = 0; eopf = 0; in_evt = '0; in_clr = '0; out_evt = '0; out_clr = '0;
    glb_clr = '0; in_we = 0; out_we = 0;
    act = {in_sts, out_sts, glb_sts, irq};
    exp = {v.exp_in, v.exp_out, v.exp_glb, v.exp_irq};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d in/out/glb/irq actual %h expected %h", v.req, act, exp);
    end
  endtask

  function automatic vec_t mk(input logic [3:0] r, input logic [9:0] ie,
      input logic [9:0] ic, input logic [9:0] oe, input logic [9:0] oc,
      input logic [9:0] xi, input logic [9:0] xo, input logic xq);
    mk = '{r, 1'b0, 1'b0, ie, ic, oe, oc, 3'b000, xi, xo, 3'b000, xq};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    n_chk++; // R1 reset state
    if ({in_sts, out_sts, glb_sts, irq} !== 24'h0) begin
      n_fail++;
      $display("FAIL R1 reset actual %h expected 0", {in_sts, out_sts, glb_sts, irq});
    end
    run(mk(4'd1, 10'h001, 10'h000, 10'h000, 10'h000, 10'h001, 10'h000, 1'b0)); // R1 masked
    run(mk(4'd3, 10'h000, 10'h001, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0));
    in_we = 1; in_m = 2'b11; out_we = 1; out_m = 2'b11;
    run(mk(4'd11, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0));
    foreach (TBL[i]) run(TBL[i]);
    in_we = 1; in_m = 2'b10;
    run(mk(4'd9, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0));
    run(mk(4'd9, 10'h001, 10'h000, 10'h000, 10'h000, 10'h001, 10'h000, 1'b0)); // R9 ep0 src0 masked
    run(mk(4'd9, 10'h080, 10'h000, 10'h000, 10'h000, 10'h081, 10'h000, 1'b1)); // R9 src1 live
    run(mk(4'd3, 10'h000, 10'h081, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0));
    out_we = 1; out_m = 2'b01;
    run(mk(4'd10, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0));
    run(mk(4'd10, 10'h000, 10'h000, 10'h002, 10'h000, 10'h000, 10'h002, 1'b0)); // R10 out src1 masked
    run(mk(4'd10, 10'h002, 10'h000, 10'h000, 10'h000, 10'h002, 10'h002, 1'b1)); // R10 in src1 independent
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule